// File: doc/BRIEF.md
# RGBA to 18-bit Pixel Packer

This block takes a stream of 32-bit pixels that hold four 8-bit channels. It turns them into the byte stream that a panel with 6 bits per colour channel expects. For every pixel it keeps the three colour channels and drops the fourth (alpha) channel. Each kept channel is reduced to its six most significant bits and sent as one byte, so every pixel becomes exactly three output bytes.

Pixels arrive on a valid/ready word port and bytes leave on a valid/ready byte port. A row-length input gives the number of pixels in one panel row. The block marks the first byte of each row and the last byte of each row, so that a downstream command sequencer can frame the row writes. Only one pixel is held at a time. A new pixel is taken only after the last byte of the previous pixel has left the block.

Top module: `rgba_to_rgb666`

## Requirements
- R1: For an accepted pixel, the block emits three bytes, low channel first. Byte k (k = 0, 1, 2) carries input bits [8k+7:8k] shifted right by two, so byte 0 is bits 7:2, byte 1 is bits 15:10 and byte 2 is bits 23:18.
- R2: Input bits 31:24 (alpha) have no effect on any output, and they produce no byte of their own.
- R3: Every output byte holds its 6-bit value in bits 5:0, and bits 7:6 are zero.
- R4: A row of N pixels produces exactly 3×N output bytes. One row may hold up to MAX_PIX pixels (default 160, so 480 bytes).
- R5: `out_sor` is high only on byte 0 of the first pixel of a row. `out_eor` is high only on byte 2 of the pixel that completes the row, where the row is completed by pixel number `row_len` counted from the row start.
- R6: `in_ready` is low from the cycle after a pixel is accepted until its third byte has been accepted downstream. While any byte is pending, `in_ready` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte`, `out_sor` and `out_eor` stay unchanged.
- R8: A `row_len` of 0 behaves as 1, so every pixel is a complete row. `row_len` is evaluated when each pixel's third byte is accepted, and it must stay steady within a row.
- R9: After reset, `out_valid` is low, `in_ready` is high and the next pixel starts a new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| row_len | input | $clog2(MAX_PIX+1) | Pixels per row (0 behaves as 1) |
| in_valid | input | 1 | Input pixel is valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | 32 | Pixel, channel 0 in bits 7:0, alpha in bits 31:24 |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | 6-bit channel value in bits 5:0 |
| out_sor | output | 1 | First byte of a row |
| out_eor | output | 1 | Last byte of a row |

## Verification
A corrupted lane index shows at the ports on the very next accepted byte. The byte would carry the wrong channel, or the pixel would release `in_ready` after too few or too many bytes, which also shifts every later byte against the model. A wrong row-position count stays hidden until the end of the current row. There, `out_eor` appears on the wrong pixel and `out_sor` moves with it, so the bench compares both marks on every byte across rows of many lengths, including one-pixel rows and a full-width row. Stall behaviour is checked under random downstream backpressure, where a byte that changes while held would show up within one cycle.

// File: rtl/rgb666_pkg.sv
package rgb666_pkg;
    localparam int PX_CHANNELS   = 4;
    localparam int KEEP_CHANNELS = 3;
    localparam int CH_W          = 8;
    localparam int DROP_BITS     = 2;
    localparam int KEPT_W        = CH_W - DROP_BITS;
    localparam int PX_W          = PX_CHANNELS * CH_W;
    localparam int LANE_W        = $clog2(KEEP_CHANNELS);

    typedef logic [KEEP_CHANNELS-1:0][KEPT_W-1:0] chan_vec_t;

    typedef struct packed {
        logic              full;
        logic [LANE_W-1:0] lane;
        chan_vec_t         chan;
    } hold_state_t;
endpackage

// File: rtl/chan_trunc.sv
module chan_trunc
    import rgb666_pkg::*;
(
    input  logic [PX_W-1:0] word,
    output chan_vec_t       chans
);
    logic [KEEP_CHANNELS*DROP_BITS-1:0] low_bits;

    for (genvar g = 0; g < KEEP_CHANNELS; g++) begin : g_lane
        assign chans[g] = word[g*CH_W + DROP_BITS +: KEPT_W];
        assign low_bits[g*DROP_BITS +: DROP_BITS] = word[g*CH_W +: DROP_BITS];
    end

    // dropped low bits and the discarded channels are deliberately unused
    logic unused_dropped;
    assign unused_dropped = ^{low_bits, word[PX_W-1:KEEP_CHANNELS*CH_W]};
endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] row_len,
    output logic             first,
    output logic             last
);
    typedef struct packed {
        logic [CNT_W-1:0] pix;
    } trk_t;

    trk_t trk_d, trk_q;

    assign first = (trk_q.pix == '0);
    assign last  = ({1'b0, trk_q.pix} + (CNT_W+1)'(1)) >= {1'b0, row_len};

    always_comb begin
        trk_d = trk_q;
        if (step) begin
            trk_d.pix = last ? '0 : trk_q.pix + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/rgba_to_rgb666.sv
module rgba_to_rgb666
    import rgb666_pkg::*;
#(
    parameter int MAX_PIX = 160,
    localparam int RL_W   = $clog2(MAX_PIX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RL_W-1:0] row_len,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [PX_W-1:0] in_pixel,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [CH_W-1:0] out_byte,
    output logic            out_sor,
    output logic            out_eor
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(KEEP_CHANNELS - 1);

    hold_state_t st_d, st_q;
    chan_vec_t   trunc;
    logic        row_first, row_last;
    logic        last_lane, pix_done, take_in, give_out;

    chan_trunc u_trunc (
        .word  (in_pixel),
        .chans (trunc)
    );

    row_tracker #(.CNT_W(RL_W)) u_row (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (pix_done),
        .row_len (row_len),
        .first   (row_first),
        .last    (row_last)
    );

    assign last_lane = (st_q.lane == LAST_LANE);
    assign in_ready  = !st_q.full;
    assign out_valid = st_q.full;
    assign out_byte  = {{DROP_BITS{1'b0}}, st_q.chan[st_q.lane]};
    assign out_sor   = st_q.full && row_first && (st_q.lane == '0);
    assign out_eor   = st_q.full && row_last && last_lane;
    assign take_in   = in_valid && in_ready;
    assign give_out  = out_valid && out_ready;
    assign pix_done  = give_out && last_lane;

    always_comb begin
        st_d = st_q;
        if (take_in) begin
            st_d.full = 1'b1;
            st_d.lane = '0;
            st_d.chan = trunc;
        end else if (give_out) begin
            if (last_lane) st_d.full = 1'b0;
            else           st_d.lane = st_q.lane + LANE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rgba_to_rgb666_chk.sv
module rgba_to_rgb666_chk #(
    parameter int RL_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RL_W-1:0] row_len,
    input logic            in_valid,
    input logic            in_ready,
    input logic [31:0]     in_pixel,
    input logic            out_valid,
    input logic            out_ready,
    input logic [7:0]      out_byte,
    input logic            out_sor,
    input logic            out_eor
);
    logic [1:0]  lane_cnt;
    logic [15:0] row_bytes;
    int          eff_len;

    assign eff_len = (row_len == '0) ? 1 : int'(row_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_cnt  <= '0;
            row_bytes <= '0;
        end else if (out_valid && out_ready) begin
            lane_cnt  <= (lane_cnt == 2'd2) ? 2'd0 : lane_cnt + 2'd1;
            row_bytes <= out_eor ? 16'd0 : row_bytes + 16'd1;
        end
    end

    a_r1_first_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_byte == {2'b00, $past(in_pixel[7:2])}));

    a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)
                                       && $stable(out_sor) && $stable(out_eor)));

    a_r5_sor_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sor) |-> (lane_cnt == 2'd0));

    a_r5_eor_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eor) |-> (lane_cnt == 2'd2));

    a_r4_row_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eor) |-> (int'(row_bytes) + 1 == 3 * eff_len));
endmodule

bind rgba_to_rgb666 rgba_to_rgb666_chk #(.RL_W(RL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_len   (row_len),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pixel  (in_pixel),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_sor   (out_sor),
    .out_eor   (out_eor)
);

// File: tb/rgba_to_rgb666_test.sv
`timescale 1ns/1ps
module rgba_to_rgb666_test;
    localparam int MAX_PIX = 160;
    localparam int RL_W    = $clog2(MAX_PIX + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [RL_W-1:0] row_len = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [31:0]     in_pixel = '0;
    logic            out_valid;
    logic            out_ready = 1'b0;
    logic [7:0]      out_byte;
    logic            out_sor, out_eor;

    int compared = 0;
    int mismatched = 0;
    int bytes_seen = 0;
    int bytes_expected = 0;
    logic bp_mode = 1'b0;
    logic [9:0] exp_q[$];   // {sor, eor, byte}

    always #2.5 clk = ~clk;

    rgba_to_rgb666 #(.MAX_PIX(MAX_PIX)) uut (
        .clk(clk), .rst_n(rst_n), .row_len(row_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_sor(out_sor), .out_eor(out_eor)
    );

    // table: pixel word, expected {byte2, byte1, byte0}
    localparam logic [55:0] VEC [6] = '{
        {32'h12345678, 24'h0D151E},
        {32'hFFFFFFFF, 24'h3F3F3F},
        {32'h00000000, 24'h000000},
        {32'hA5C38107, 24'h302001},
        {32'h00FC0380, 24'h3F0020},
        {32'hFF000000, 24'h000000}
    };

    function automatic logic [23:0] model(input logic [31:0] w);
        return {2'b00, w[23:18], 2'b00, w[15:10], 2'b00, w[7:2]};
    endfunction

    always @(posedge clk) begin
        #1 out_ready <= bp_mode ? 1'($urandom % 2) : 1'b1;
    end

    // monitor, sampled mid-cycle
    logic       prev_stall = 1'b0;
    logic [9:0] prev_out = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                compared++;
                if (!out_valid || {out_sor, out_eor, out_byte} != prev_out) begin
                    mismatched++;
                    $display("FAIL R7 held output changed: got v=%b %h exp v=1 %h",
                             out_valid, {out_sor, out_eor, out_byte}, prev_out);
                end
            end
            if (out_valid) begin
                compared++;
                if (in_ready) begin
                    mismatched++;
                    $display("FAIL R6 in_ready=%b while byte pending, exp 0", in_ready);
                end
            end
            if (out_valid && out_ready) begin
                bytes_seen++;
                compared++;
                if (exp_q.size() == 0) begin
                    mismatched++;
                    $display("FAIL R4 extra byte %h, exp none", out_byte);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    if (out_byte[7:6] != 2'b00) begin
                        mismatched++;
                        $display("FAIL R3 byte %h top bits nonzero, exp %h", out_byte, e[7:0]);
                    end else if (out_byte != e[7:0]) begin
                        mismatched++;
                        $display("FAIL R1 byte got %h exp %h", out_byte, e[7:0]);
                    end else if ({out_sor, out_eor} != e[9:8]) begin
                        mismatched++;
                        $display("FAIL R5 marks sor/eor got %b exp %b", {out_sor, out_eor}, e[9:8]);
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_sor, out_eor, out_byte};
        end
    end

    task automatic put_pixel(input logic [31:0] w, input logic [23:0] ex,
                             input logic sor_e, input logic eor_e);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_pixel = w;
        do @(negedge clk); while (!in_ready);
        exp_q.push_back({sor_e, 1'b0, ex[7:0]});
        exp_q.push_back({1'b0, 1'b0, ex[15:8]});
        exp_q.push_back({1'b0, eor_e, ex[23:16]});
        bytes_expected += 3;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_pixel = $urandom;
    endtask

    task automatic drain();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while ((exp_q.size() != 0 || out_valid) && guard < 5000);
    endtask

    task automatic random_row(input int len_set, input int npix);
        int eff = (len_set == 0) ? 1 : len_set;
        row_len = RL_W'(len_set);
        for (int i = 0; i < npix; i++) begin
            logic [31:0] w = $urandom;
            put_pixel(w, model(w), (i % eff) == 0, (i % eff) == eff - 1);
        end
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired, exp run to complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R9: reset state
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            mismatched++;
            $display("FAIL R9 in reset out_valid=%b in_ready=%b exp 0/1", out_valid, in_ready);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            mismatched++;
            $display("FAIL R9 after reset out_valid=%b in_ready=%b exp 0/1", out_valid, in_ready);
        end

        // table walk, rows of 3 pixels (R1, R2, R3, R5)
        row_len = RL_W'(3);
        for (int i = 0; i < 6; i++) begin
            put_pixel(VEC[i][55:24], VEC[i][23:0], (i % 3) == 0, (i % 3) == 2);
        end
        drain();

        // R2: alpha alone differs, same bytes expected
        row_len = RL_W'(2);
        put_pixel(32'h00ABCDEF, model(32'h00ABCDEF), 1'b1, 1'b0);
        put_pixel(32'h5AABCDEF, model(32'h00ABCDEF), 1'b0, 1'b1);
        drain();

        // R8: zero row length gives one-pixel rows; R5 with length 1
        random_row(0, 4);
        random_row(1, 3);

        // R4/R5 random rows under backpressure (R7)
        bp_mode = 1'b1;
        for (int r = 0; r < 30; r++) begin
            int len = 1 + int'($urandom % 12);
            random_row(len, len * (1 + int'($urandom % 2)));
        end
        // R4: full-width row
        random_row(MAX_PIX, MAX_PIX);
        bp_mode = 1'b0;
        random_row(MAX_PIX, MAX_PIX);

        // R4: total byte count
        compared++;
        if (bytes_seen != bytes_expected) begin
            mismatched++;
            $display("FAIL R4 byte total got %0d exp %0d", bytes_seen, bytes_expected);
        end

        // R9: reset mid-pixel clears pending byte and row position
        row_len = RL_W'(4);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_pixel = 32'h01020304;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        bp_mode = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            mismatched++;
            $display("FAIL R9 reset mid-pixel out_valid=%b in_ready=%b exp 0/1", out_valid, in_ready);
        end
        random_row(4, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule